// File: doc/BRIEF.md
# Buffer Pool Flow-Control Monitor

The monitor tracks how much buffer memory each of a set of pools holds and converts that occupancy into per-port pause requests with hysteresis. Every frame buffer allocation or release arrives as a one-cycle event that carries a port number, an internal priority (0 to 7) and a size in units. A per-port steering word picks the pool for each priority. An allocation is admitted only if the pool stays within its upper limit. A refused allocation is reported as a drop and leaves the pool untouched.

Each pool holds three limits in a compact 12-bit code: an upper bound, a pause-on level and a pause-off level. It also holds an enable bit and a mask of the ports that its pause condition reaches. A single write port loads all of this configuration. Its `cfg_kind` field selects the item and `cfg_idx` selects the pool or the port. The pause outputs feed the transmit side of the MACs. The monitor stores no frames and builds no frames.

Top module: `bpfc_monitor`

## Requirements
- R1: A 12-bit limit code decodes to mantissa times two to the power of the exponent, where the mantissa is bits 11:4 and the exponent is bits 3:0. For example, 0x334 decodes to 816, 0x533 to 664, 0x3C3 to 480 and 0x0A2 to 40.
- R2: An allocation whose size, added to the pool's occupancy, is less than or equal to the decoded upper limit is admitted. The pool grows by the size, and `ev_admit` is high for the cycle after the event.
- R3: An allocation that would exceed the upper limit is refused. `ev_drop` is high for the cycle after the event, and the pool's occupancy is unchanged.
- R4: A release subtracts its size from the pool. A release larger than the occupancy leaves the pool at zero and sets `underflow_err`, which stays high until reset.
- R5: A pool's pause condition becomes active on the clock edge at which its occupancy reaches or passes the decoded on level.
- R6: Once active, the pause condition stays active while the occupancy is above the decoded off level. It clears when the occupancy is at or below the off level. Below the on level it does not re-arm until the on level is reached again.
- R7: `pause_req[p]` is the OR, over every pool whose enable bit is 1 and whose port mask has bit p set, of that pool's pause condition. A disabled pool contributes nothing.
- R8: For an event on port p with priority n, the pool index is bits 8n+7:8n of port p's 64-bit steering word. An index at or above the pool count makes an allocation a drop and makes a release have no effect.
- R9: After reset, each port owns pools/ports consecutive pools, starting at pool p times that count. With two pools per port, priorities 0 to 3 use the port's first pool and priorities 4 to 7 use its second pool.
- R10: After reset, every pool is empty with upper-limit code 0x334, on and off codes 0, enable 0 and mask 0. `ev_admit`, `ev_drop`, `pause_req` and `underflow_err` are all low.
- R11: A configuration write applies on the next clock edge. `cfg_kind` selects the item: 0 is the upper-limit code, 1 the on code, 2 the off code, 3 the enable bit (`cfg_data[0]`), 4 the port mask (`cfg_data[NUM_PORTS-1:0]`) and 5 the steering word (with `cfg_idx` as the port). Codes are taken from `cfg_data[11:0]`.
- R12: A release never produces `ev_admit` or `ev_drop`, and the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Configuration item selector |
| cfg_idx | input | 8 | Pool index, or port index for steering words |
| cfg_data | input | 64 | Configuration value |
| ev_valid | input | 1 | Buffer event strobe |
| ev_free | input | 1 | 1 = release, 0 = allocation |
| ev_port | input | PORT_W | Port of the event |
| ev_prio | input | 3 | Internal priority of the event |
| ev_size | input | SIZE_W | Size of the event in units |
| ev_admit | output | 1 | Allocation admitted (one cycle after event) |
| ev_drop | output | 1 | Allocation refused (one cycle after event) |
| pause_req | output | NUM_PORTS | Per-port pause request |
| underflow_err | output | 1 | Sticky release-underflow flag |

## Verification
The bench builds the monitor with its defaults of four ports and eight pools. This gives two pools per port, so the reset steering splits the priorities into the two halves. Each port's pools can be tested apart from its neighbours. Eight pools also let a rewritten steering word send traffic from one port into a pool that belongs to another port, and let a byte point past the last pool. Sizes of 16 bits reach the exact upper limit of 816 in a single event, which tests the boundary between admit and drop.

// File: rtl/bpfc_pkg.sv
package bpfc_pkg;

  localparam int CODE_W   = 12;
  localparam int MANT_W   = 8;
  localparam int EXP_W    = 4;
  localparam int THR_W    = MANT_W + (1 << EXP_W) - 1;
  localparam int PRIO_NUM = 8;
  localparam int IDX_W    = 8;
  localparam int MAP_W    = PRIO_NUM * IDX_W;

  typedef enum logic [2:0] {
    CFG_MAX  = 3'd0,
    CFG_ON   = 3'd1,
    CFG_OFF  = 3'd2,
    CFG_EN   = 3'd3,
    CFG_MASK = 3'd4,
    CFG_MAP  = 3'd5
  } cfg_kind_e;

  // mantissa in the upper byte, exponent in the low nibble
  function automatic logic [THR_W-1:0] thr_decode(input logic [CODE_W-1:0] code);
    return THR_W'(code[CODE_W-1:EXP_W]) << code[EXP_W-1:0];
  endfunction

  // reset steering: leading priorities share the first pool, the rest step by q
  function automatic logic [MAP_W-1:0] default_map_word(input int port, input int pools,
                                                        input int ports);
    int per;
    int q;
    int head;
    int base;
    int idx;
    logic [MAP_W-1:0] word;
    per = pools / ports;
    if (per < 1) per = 1;
    if (per > PRIO_NUM) per = PRIO_NUM;
    q    = PRIO_NUM / per;
    head = q + (PRIO_NUM % per);
    base = port * per;
    word = '0;
    for (int n = 0; n < PRIO_NUM; n++) begin
      idx = (n < head) ? base : base + (n - head) / q + 1;
      word[n*IDX_W +: IDX_W] = IDX_W'(idx);
    end
    return word;
  endfunction

endpackage

// File: rtl/bpfc_map.sv
module bpfc_map
  import bpfc_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_POOLS = 8,
  parameter int PORT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [MAP_W-1:0]  wr_word,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [2:0]        rd_prio,
  output logic [IDX_W-1:0]  pool_idx
);

  logic [MAP_W-1:0] map_q [NUM_PORTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PORTS; p++)
        map_q[p] <= default_map_word(p, NUM_POOLS, NUM_PORTS);
    end else if (wr_en) begin
      map_q[wr_port] <= wr_word;
    end
  end

  logic [MAP_W-1:0] sel_word;
  assign sel_word = map_q[rd_port];
  assign pool_idx = sel_word[rd_prio*IDX_W +: IDX_W];

  // R8: a steering write lands in the addressed port's word
  assert_map_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> map_q[$past(wr_port)] == $past(wr_word));

endmodule

// File: rtl/bpfc_pool.sv
module bpfc_pool
  import bpfc_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int OCC_W        = 24,
  parameter int SIZE_W       = 16,
  parameter logic [11:0] RST_MAX_CODE = 12'h334
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_kind,
  input  logic [CODE_W-1:0]    cfg_code,
  input  logic [NUM_PORTS-1:0] cfg_mask,
  input  logic                 ev_hit,
  input  logic                 ev_free,
  input  logic [SIZE_W-1:0]    ev_size,
  output logic                 fits_o,
  output logic                 underflow_o,
  output logic                 pause_o,
  output logic [NUM_PORTS-1:0] port_mask_o
);

  localparam int CMP_W = ((OCC_W > THR_W) ? OCC_W : THR_W) + 1;

  logic [OCC_W-1:0]     occ_q, occ_next;
  logic [CODE_W-1:0]    max_code_q, on_code_q, off_code_q;
  logic                 en_q, fc_q, fc_next;
  logic [NUM_PORTS-1:0] mask_q;

  logic [THR_W-1:0] max_thr, on_thr, off_thr;
  logic [CMP_W-1:0] sum_w;

  assign max_thr = thr_decode(max_code_q);
  assign on_thr  = thr_decode(on_code_q);
  assign off_thr = thr_decode(off_code_q);

  assign sum_w       = CMP_W'(occ_q) + CMP_W'(ev_size);
  assign fits_o      = sum_w <= CMP_W'(max_thr);
  assign underflow_o = ev_hit && ev_free && (CMP_W'(ev_size) > CMP_W'(occ_q));

  always_comb begin
    occ_next = occ_q;
    if (ev_hit && !ev_free && fits_o) occ_next = sum_w[OCC_W-1:0];
    else if (ev_hit && ev_free)       occ_next = underflow_o ? '0 : occ_q - OCC_W'(ev_size);
  end

  // hysteresis on the occupancy being written this edge
  always_comb begin
    fc_next = fc_q;
    if (CMP_W'(occ_next) >= CMP_W'(on_thr))       fc_next = 1'b1;
    else if (CMP_W'(occ_next) <= CMP_W'(off_thr)) fc_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q      <= '0;
      fc_q       <= 1'b0;
      max_code_q <= RST_MAX_CODE;
      on_code_q  <= '0;
      off_code_q <= '0;
      en_q       <= 1'b0;
      mask_q     <= '0;
    end else begin
      occ_q <= occ_next;
      fc_q  <= fc_next;
      if (cfg_we) begin
        case (cfg_kind)
          CFG_MAX:  max_code_q <= cfg_code;
          CFG_ON:   on_code_q  <= cfg_code;
          CFG_OFF:  off_code_q <= cfg_code;
          CFG_EN:   en_q       <= cfg_code[0];
          CFG_MASK: mask_q     <= cfg_mask;
          default:  ;
        endcase
      end
    end
  end

  assign pause_o     = fc_q && en_q;
  assign port_mask_o = mask_q;

  assert_admit_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && !ev_free && fits_o) |=> occ_q == $past(occ_q) + OCC_W'($past(ev_size)));

  assert_refuse_keeps_occ_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && !ev_free && !fits_o) |=> $stable(occ_q));

  assert_clamp_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> occ_q == '0);

  assert_on_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fc_q) && !$past(cfg_we)) |-> CMP_W'(occ_q) >= CMP_W'(on_thr));

  assert_off_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fc_q) && !$past(cfg_we)) |-> CMP_W'(occ_q) <= CMP_W'(off_thr));

endmodule

// File: rtl/bpfc_monitor.sv
module bpfc_monitor
  import bpfc_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_POOLS = 8,
  parameter int OCC_W     = 24,
  parameter int SIZE_W    = 16,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_kind,
  input  logic [7:0]           cfg_idx,
  input  logic [63:0]          cfg_data,
  input  logic                 ev_valid,
  input  logic                 ev_free,
  input  logic [PORT_W-1:0]    ev_port,
  input  logic [2:0]           ev_prio,
  input  logic [SIZE_W-1:0]    ev_size,
  output logic                 ev_admit,
  output logic                 ev_drop,
  output logic [NUM_PORTS-1:0] pause_req,
  output logic                 underflow_err
);

  logic [IDX_W-1:0]     pool_idx;
  logic                 map_we, route_ok;
  logic [NUM_POOLS-1:0] hit_v, fits_v, uf_v, pause_v, pool_we;
  logic [NUM_PORTS-1:0] mask_a [NUM_POOLS];
  logic                 fits_any;

  assign map_we = cfg_we && (cfg_kind == CFG_MAP) && (cfg_idx < 8'(NUM_PORTS));

  bpfc_map #(.NUM_PORTS(NUM_PORTS), .NUM_POOLS(NUM_POOLS), .PORT_W(PORT_W)) map_i (
    .clk(clk), .rst_n(rst_n), .wr_en(map_we), .wr_port(cfg_idx[PORT_W-1:0]),
    .wr_word(cfg_data), .rd_port(ev_port), .rd_prio(ev_prio), .pool_idx(pool_idx)
  );

  assign route_ok = ev_valid && (32'(ev_port) < NUM_PORTS) && (32'(pool_idx) < NUM_POOLS);

  for (genvar i = 0; i < NUM_POOLS; i++) begin : g_pool
    assign hit_v[i]   = route_ok && (32'(pool_idx) == i);
    assign pool_we[i] = cfg_we && (cfg_kind != CFG_MAP) && (32'(cfg_idx) == i);
    bpfc_pool #(.NUM_PORTS(NUM_PORTS), .OCC_W(OCC_W), .SIZE_W(SIZE_W)) pool_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(pool_we[i]), .cfg_kind(cfg_kind),
      .cfg_code(cfg_data[CODE_W-1:0]), .cfg_mask(cfg_data[NUM_PORTS-1:0]),
      .ev_hit(hit_v[i]), .ev_free(ev_free), .ev_size(ev_size),
      .fits_o(fits_v[i]), .underflow_o(uf_v[i]), .pause_o(pause_v[i]),
      .port_mask_o(mask_a[i])
    );
  end

  assign fits_any = |(hit_v & fits_v);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_admit      <= 1'b0;
      ev_drop       <= 1'b0;
      underflow_err <= 1'b0;
    end else begin
      ev_admit      <= ev_valid && !ev_free && fits_any;
      ev_drop       <= ev_valid && !ev_free && !fits_any;
      underflow_err <= underflow_err || (|uf_v);
    end
  end

  always_comb begin
    pause_req = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      for (int i = 0; i < NUM_POOLS; i++)
        pause_req[p] = pause_req[p] | (pause_v[i] & mask_a[i][p]);
  end

  assert_verdict_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_admit, ev_drop}));

  assert_free_no_verdict_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_free) |=> !ev_admit && !ev_drop);

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);

  assert_bad_route_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_free && !route_ok) |=> ev_drop);

endmodule

// File: tb/bpfc_monitor_tb.sv
module bpfc_monitor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_kind = '0;
  logic [7:0]  cfg_idx = '0;
  logic [63:0] cfg_data = '0;
  logic        ev_valid = 1'b0;
  logic        ev_free = 1'b0;
  logic [1:0]  ev_port = '0;
  logic [2:0]  ev_prio = '0;
  logic [15:0] ev_size = '0;
  logic        ev_admit, ev_drop, underflow_err;
  logic [3:0]  pause_req;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  bpfc_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .ev_valid(ev_valid), .ev_free(ev_free), .ev_port(ev_port),
    .ev_prio(ev_prio), .ev_size(ev_size), .ev_admit(ev_admit), .ev_drop(ev_drop),
    .pause_req(pause_req), .underflow_err(underflow_err)
  );

  function automatic int dec(input logic [11:0] code);
    return int'(code[11:4]) * (2 ** int'(code[3:0]));
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg(input int kind, input int idx, input logic [63:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_idx = 8'(idx); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ev(input bit fr, input int port, input int prio, input int size);
    @(negedge clk);
    ev_valid = 1'b1; ev_free = fr; ev_port = 2'(port); ev_prio = 3'(prio); ev_size = 16'(size);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic alloc_exp(input string req, input int port, input int prio, input int size,
                           input bit admit);
    ev(1'b0, port, prio, size);
    chk(req, "admit", ev_admit, admit);
    chk(req, "drop", ev_drop, !admit);
  endtask

  task automatic free_exp(input string req, input int port, input int prio, input int size);
    ev(1'b1, port, prio, size);
    chk(req, "release verdict", {ev_admit, ev_drop}, 0);
  endtask

  task automatic t_reset;
    chk("R10", "admit", ev_admit, 0);
    chk("R10", "drop", ev_drop, 0);
    chk("R10", "pause", pause_req, 0);
    chk("R10", "underflow_err", underflow_err, 0);
  endtask

  task automatic t_default_limits;
    int lim;
    lim = dec(12'h334);
    chk("R1", "decode 0x334", lim, 816);
    for (int p = 0; p < 4; p++) begin
      alloc_exp("R9", p, 0, lim, 1'b1);
      alloc_exp("R9", p, 4, 1, 1'b1);
      alloc_exp("R9", p, 3, 1, 1'b0);
      free_exp("R12", p, 2, lim);
      free_exp("R12", p, 7, 1);
    end
    alloc_exp("R2", 0, 0, 800, 1'b1);
    alloc_exp("R3", 0, 1, 17, 1'b0);
    alloc_exp("R3", 0, 2, 16, 1'b1);
    free_exp("R4", 0, 0, 816);
    alloc_exp("R2", 0, 0, 816, 1'b1);
    free_exp("R4", 0, 0, 816);
  endtask

  task automatic t_custom_max;
    cfg(0, 1, 64'h0A2);
    chk("R1", "decode 0x0A2", dec(12'h0A2), 40);
    alloc_exp("R11", 0, 4, 41, 1'b0);
    alloc_exp("R11", 0, 7, 40, 1'b1);
    alloc_exp("R3", 0, 5, 1, 1'b0);
    free_exp("R4", 0, 6, 40);
  endtask

  task automatic t_hysteresis;
    cfg(1, 2, 64'h533);
    cfg(2, 2, 64'h3C3);
    cfg(4, 2, 64'b1010);
    cfg(3, 2, 64'h1);
    chk("R10", "pause before traffic", pause_req, 0);
    alloc_exp("R5", 1, 0, 600, 1'b1);
    chk("R5", "pause below on", pause_req, 0);
    alloc_exp("R5", 1, 1, dec(12'h533) - 600, 1'b1);
    chk("R5", "pause at on level", pause_req, 4'b1010);
    free_exp("R6", 1, 2, 100);
    chk("R6", "pause held above off", pause_req, 4'b1010);
    free_exp("R6", 1, 3, 564 - dec(12'h3C3));
    chk("R6", "pause cleared at off", pause_req, 0);
    alloc_exp("R6", 1, 0, 100, 1'b1);
    chk("R6", "no re-arm below on", pause_req, 0);
    alloc_exp("R5", 1, 0, 84, 1'b1);
    chk("R5", "re-armed at on", pause_req, 4'b1010);
    free_exp("R6", 1, 0, 664);
    chk("R6", "empty pool", pause_req, 0);
  endtask

  task automatic t_or_and_disable;
    cfg(1, 3, 64'h0A0);
    cfg(2, 3, 64'h050);
    cfg(4, 3, 64'b0001);
    cfg(3, 3, 64'h1);
    alloc_exp("R7", 1, 5, 10, 1'b1);
    chk("R7", "second pool alone", pause_req, 4'b0001);
    alloc_exp("R7", 1, 0, 700, 1'b1);
    chk("R7", "OR of two pools", pause_req, 4'b1011);
    cfg(3, 3, 64'h0);
    chk("R7", "disabled pool masked", pause_req, 4'b1010);
    free_exp("R7", 1, 0, 700);
    chk("R7", "all clear", pause_req, 0);
    free_exp("R7", 1, 5, 10);
  endtask

  task automatic t_steering;
    cfg(5, 2, 64'h0707_0707_07FF_0707);
    cfg(0, 7, 64'h050);
    alloc_exp("R8", 2, 0, 5, 1'b1);
    alloc_exp("R8", 3, 6, 1, 1'b0);
    alloc_exp("R8", 2, 2, 1, 1'b0);
    free_exp("R8", 2, 2, 100);
    chk("R8", "ignored release no error", underflow_err, 0);
    free_exp("R8", 2, 5, 5);
    alloc_exp("R8", 3, 4, 5, 1'b1);
    free_exp("R8", 3, 4, 5);
    chk("R8", "pool 7 no error", underflow_err, 0);
  endtask

  task automatic t_underflow;
    alloc_exp("R4", 0, 0, 10, 1'b1);
    free_exp("R4", 0, 0, 15);
    chk("R4", "underflow flag", underflow_err, 1);
    alloc_exp("R4", 0, 1, 816, 1'b1);
    chk("R4", "flag sticky", underflow_err, 1);
    free_exp("R4", 0, 1, 816);
    chk("R4", "flag still set", underflow_err, 1);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_limits();
    t_custom_max();
    t_hysteresis();
    t_or_and_disable();
    t_steering();
    t_underflow();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual run still going, expected completion");
    summary();
  end

endmodule